// File: doc/BRIEF.md
# Byte-Streamed 8x8 Bit Transpose Register

The block takes an 8x8 bit matrix as eight bytes, one byte per accepted write, and hands back the matrix turned by ninety degrees as eight bytes, one per accepted read strobe. Each input byte is one column of the matrix, with its most significant bit in the top row. The first byte written is the leftmost column. Output byte k is the k-th row read from left to right. The first input byte gives the MSB of every output byte and the last input byte gives the LSB.

A typical use sits in front of a multiplexed seven-segment display driver that is wired to common-anode digits. Such a driver scans segments rather than digits. Software writes one segment pattern per digit, then reads back bytes that each say which digits light one given segment. Capture builds the rows while the bytes arrive, so the transpose can be read in the cycle after the eighth write, with no extra processing cycles.

Top module: `transp_8x8`

## Requirements
- R1: While `rst_ni` is low, `done_o`, `rd_valid_o` and `rd_data_o` are all zero, and both byte counters are cleared.
- R2: Call input byte j (j = 0 is the first byte written) in[j], and output byte k (k = 0 is the first byte read) out[k]. Then bit (7-j) of out[k] equals bit (7-k) of in[j], for any matrix. Applying the transpose twice returns the original eight bytes.
- R3: `done_o` is low until the eighth accepted write. It reads 1 in the cycle after the clock edge that takes the eighth byte, and the first read strobe may follow at once.
- R4: A write presented while `done_o` is high is ignored. It does not change any byte that is read out afterwards.
- R5: A read strobe while `done_o` is high loads the next output byte into `rd_data_o` at that clock edge, in order out[0] to out[7]. `rd_valid_o` is high for exactly the one cycle after each accepted strobe.
- R6: `rd_data_o` holds its value until the next accepted strobe. A strobe while `done_o` is low is ignored: no `rd_valid_o`, and no change to `rd_data_o`.
- R7: The clock edge that accepts the eighth read strobe clears `done_o` and wraps the read counter. A write presented in that same cycle is ignored. The next eight writes form a fresh matrix.
- R8: Writing 0xF1, 0x39, 0x27, 0x0E, 0x7B, 0x16, 0x4B, 0x0F reads back as 0x80, 0x8A, 0xE8, 0xCC, 0x5B, 0x35, 0x3F, 0xEB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Write request for `wr_data_i` |
| wr_data_i | input | 8 | Input column byte, MSB = top row |
| rd_strobe_i | input | 1 | Request for the next output byte |
| rd_data_o | output | 8 | Registered output row byte |
| rd_valid_o | output | 1 | One-cycle pulse after an accepted strobe |
| done_o | output | 1 | A full matrix is held and not yet drained |

## Verification
Capture and drain never run at the same time, because `done_o` gates both of them. The one cycle where the two meet is the eighth read strobe, which is the cycle that clears `done_o`. The bench presents a write of 0xFF in exactly that cycle and then loads a new matrix. If the stray byte had been taken, it would shift the columns of the new matrix, and every following output byte would miscompare in the scoreboard. A matrix that was loaded and then had extra writes pushed at it while full is drained and compared the same way.

// File: rtl/transp_pkg.sv
package transp_pkg;
  localparam int unsigned DIM_DEF = 8;
  localparam int unsigned CNT_W_DEF = $clog2(DIM_DEF);
endpackage

// File: rtl/transp_seq.sv
module transp_seq #(
  parameter int unsigned DIM = transp_pkg::DIM_DEF,
  localparam int unsigned CNT_W = $clog2(DIM)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic             rd_strobe_i,
  output logic             wr_acc_o,
  output logic             rd_acc_o,
  output logic [CNT_W-1:0] rd_idx_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIM - 1);

  logic [CNT_W-1:0] wr_cnt_q, rd_cnt_q;
  logic             done_q;

  assign wr_acc_o = wr_valid_i && !done_q;
  assign rd_acc_o = rd_strobe_i && done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_cnt_q <= '0;
      rd_cnt_q <= '0;
      done_q   <= 1'b0;
    end else begin
      if (wr_acc_o) begin
        if (wr_cnt_q == LAST) begin
          wr_cnt_q <= '0;
          done_q   <= 1'b1;
        end else begin
          wr_cnt_q <= wr_cnt_q + 1'b1;
        end
      end
      if (rd_acc_o) begin
        if (rd_cnt_q == LAST) begin
          rd_cnt_q <= '0;
          done_q   <= 1'b0;
        end else begin
          rd_cnt_q <= rd_cnt_q + 1'b1;
        end
      end
    end
  end

  assign rd_idx_o = rd_cnt_q;
  assign done_o   = done_q;
endmodule

// File: rtl/transp_matrix.sv
module transp_matrix #(
  parameter int unsigned DIM = transp_pkg::DIM_DEF,
  localparam int unsigned CNT_W = $clog2(DIM)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_en_i,
  input  logic [DIM-1:0]   din_i,
  input  logic [CNT_W-1:0] sel_i,
  output logic [DIM-1:0]   dout_o
);
  logic [DIM-1:0] row_q [DIM];

  // row k collects bit (DIM-1-k) of each column, first column lands in MSB
  for (genvar k = 0; k < DIM; k++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         row_q[k] <= '0;
      else if (shift_en_i) row_q[k] <= {row_q[k][DIM-2:0], din_i[DIM-1-k]};
    end
  end

  assign dout_o = row_q[sel_i];
endmodule

// File: rtl/transp_rd_port.sv
module transp_rd_port #(
  parameter int unsigned DIM = transp_pkg::DIM_DEF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           rd_acc_i,
  input  logic [DIM-1:0] din_i,
  output logic [DIM-1:0] rd_data_o,
  output logic           rd_valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_acc_i;
      if (rd_acc_i) rd_data_o <= din_i;
    end
  end
endmodule

// File: rtl/transp_8x8.sv
module transp_8x8 #(
  parameter int unsigned DIM = transp_pkg::DIM_DEF
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_valid_i,
  input  logic [DIM-1:0] wr_data_i,
  input  logic           rd_strobe_i,
  output logic [DIM-1:0] rd_data_o,
  output logic           rd_valid_o,
  output logic           done_o
);
  localparam int unsigned CNT_W = $clog2(DIM);

  logic             wr_acc, rd_acc;
  logic [CNT_W-1:0] rd_idx;
  logic [DIM-1:0]   row_sel;

  transp_seq #(.DIM(DIM)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .rd_strobe_i(rd_strobe_i),
    .wr_acc_o   (wr_acc),
    .rd_acc_o   (rd_acc),
    .rd_idx_o   (rd_idx),
    .done_o     (done_o)
  );

  transp_matrix #(.DIM(DIM)) i_matrix (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_en_i(wr_acc),
    .din_i     (wr_data_i),
    .sel_i     (rd_idx),
    .dout_o    (row_sel)
  );

  transp_rd_port #(.DIM(DIM)) i_rd_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_acc_i  (rd_acc),
    .din_i     (row_sel),
    .rd_data_o (rd_data_o),
    .rd_valid_o(rd_valid_o)
  );
endmodule

// File: rtl/transp_8x8_chk.sv
module transp_8x8_chk #(
  parameter int unsigned DIM = transp_pkg::DIM_DEF
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           wr_valid_i,
  input logic           rd_strobe_i,
  input logic [DIM-1:0] rd_data_o,
  input logic           rd_valid_o,
  input logic           done_o
);
  assert_valid_after_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(rd_strobe_i && done_o));

  assert_data_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_strobe_i && done_o) |=> $stable(rd_data_o));

  assert_done_rise_on_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(wr_valid_i));

  assert_done_fall_on_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_o) |-> $past(rd_strobe_i));

  assert_full_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !rd_strobe_i) |=> done_o);
endmodule

bind transp_8x8 transp_8x8_chk #(.DIM(DIM)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_valid_i (wr_valid_i),
  .rd_strobe_i(rd_strobe_i),
  .rd_data_o  (rd_data_o),
  .rd_valid_o (rd_valid_o),
  .done_o     (done_o)
);

// File: tb/test_transp_8x8.sv
`timescale 1ns/1ps
module test_transp_8x8;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_valid_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       rd_strobe_i = 1'b0;
  logic [7:0] rd_data_o;
  logic       rd_valid_o;
  logic       done_o;

  typedef logic [7:0] mat_t [8];

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] rx [8];
  int         rx_n = 0;

  transp_8x8 i_transp_8x8 (.*);

  always #5 clk_i = ~clk_i;

  function automatic void chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endfunction

  function automatic mat_t xpose(mat_t m);
    mat_t t;
    for (int k = 0; k < 8; k++)
      for (int j = 0; j < 8; j++)
        t[k][7-j] = m[j][7-k];
    return t;
  endfunction

  // monitor: pops the scoreboard on every output pulse
  always @(negedge clk_i) begin
    if (rst_ni && rd_valid_o) begin
      if (exp_q.size() == 0) chk("R5 unexpected rd_valid_o", 1, 0);
      else chk(tag_q.pop_front(), int'(rd_data_o), int'(exp_q.pop_front()));
      rx[rx_n % 8] = rd_data_o;
      rx_n++;
    end
  end

  task automatic load(mat_t m, string tag);
    mat_t t = xpose(m);
    for (int k = 0; k < 8; k++) begin
      exp_q.push_back(t[k]);
      tag_q.push_back(tag);
    end
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      if (i == 7) chk("R3 done low before 8th write", int'(done_o), 0);
      wr_valid_i = 1'b1;
      wr_data_i  = m[i];
    end
    @(negedge clk_i);
    wr_valid_i = 1'b0;
    chk("R3 done after 8th write", int'(done_o), 1);
  endtask

  task automatic drain(bit wr_last);
    logic [7:0] held;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk_i);
      rd_strobe_i = 1'b1;
      if (k == 7 && wr_last) begin
        wr_valid_i = 1'b1;
        wr_data_i  = 8'hFF;
      end
      @(negedge clk_i);
      rd_strobe_i = 1'b0;
      wr_valid_i  = 1'b0;
      if (k == 3) begin
        held = rd_data_o;
        repeat (3) @(negedge clk_i);
        chk("R6 data held between strobes", int'(rd_data_o), int'(held));
        chk("R6 no valid without strobe", int'(rd_valid_o), 0);
      end
    end
    @(negedge clk_i);
    chk("R7 done cleared after 8th read", int'(done_o), 0);
  endtask

  task automatic rand_mat(output mat_t m);
    for (int i = 0; i < 8; i++) m[i] = 8'($urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    chk("watchdog expired", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    mat_t a, b, known;
    known = '{8'hF1, 8'h39, 8'h27, 8'h0E, 8'h7B, 8'h16, 8'h4B, 8'h0F};

    repeat (2) @(negedge clk_i);
    chk("R1 done in reset", int'(done_o), 0);
    chk("R1 valid in reset", int'(rd_valid_o), 0);
    chk("R1 data in reset", int'(rd_data_o), 0);
    rst_ni = 1'b1;

    // strobe with nothing loaded
    @(negedge clk_i);
    rd_strobe_i = 1'b1;
    @(negedge clk_i);
    rd_strobe_i = 1'b0;
    chk("R6 strobe while empty: valid", int'(rd_valid_o), 0);
    chk("R6 strobe while empty: data", int'(rd_data_o), 0);

    // known vector, R8
    load(known, "R8 known vector");
    drain(1'b0);
    chk("R8 row0", int'(rx[0]), 8'h80);
    chk("R8 row7", int'(rx[7]), 8'hEB);

    // writes while full are dropped, R4
    rand_mat(a);
    load(a, "R4 writes while full");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      wr_valid_i = 1'b1;
      wr_data_i  = 8'($urandom);
    end
    @(negedge clk_i);
    wr_valid_i = 1'b0;
    drain(1'b0);

    // transpose twice gives back the original, R2
    b = rx;
    load(b, "R2 double transpose");
    drain(1'b0);
    for (int i = 0; i < 8; i++) chk("R2 double transpose restores", int'(rx[i]), int'(a[i]));

    // write in the same cycle as the final strobe, R7
    rand_mat(a);
    load(a, "R7 setup");
    drain(1'b1);
    rand_mat(b);
    load(b, "R7 fresh matrix after final strobe");
    drain(1'b0);

    for (int n = 0; n < 20; n++) begin
      rand_mat(a);
      load(a, "R2 random matrix");
      drain(1'b0);
    end

    chk("R5 scoreboard empty", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule